// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a physical memory address into the index of the DRAM row (chip-select) that holds it. Software loads a bank of boundary registers, one per row. Each register holds a cumulative upper limit in units of 64 MiB. A row owns the addresses from the limit of the row before it up to its own limit minus one. Row 0 starts at address zero. If a row's limit equals the limit of the row before it, that row is empty, and a lookup never selects it.

A lookup presents a full physical address. One cycle later the block returns the selected row, a hit flag and an out-of-range flag. In single-channel operation all eight rows take part. In dual-channel operation only the lower four rows take part. The block also checks continuously that the participating limits never decrease. If one does, it raises a configuration-error flag, and lookups report neither a hit nor out-of-range until the configuration is fixed.

Top module: `rowbnd_decoder`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[6:0]` into the boundary register chosen by `wr_idx`, and bit 7 is ignored. The new value takes effect for lookups issued in the following cycle. A lookup issued in the same cycle as the write uses the old value.
- R2: The granule index of an address is `lk_addr[32:26]`. Row i covers granule indices from the limit of row i-1 (zero for row 0) up to its own limit minus one.
- R3: A hit selects the lowest-index participating row whose limit is strictly greater than the granule index. A row whose limit equals the limit of the row before it is never reported.
- R4: With `dual_chan` low, rows 0 to 7 participate. With `dual_chan` high, only rows 0 to 3 participate, and rows 4 to 7 have no effect on lookups or on `cfg_err`.
- R5: An address whose granule index is at or above every participating limit gives `res_oor` = 1 and `res_hit` = 0.
- R6: `res_valid` is high exactly one cycle after a cycle with `lk_valid` high. While `res_valid` is low, `res_hit` and `res_oor` are low.
- R7: `cfg_err` is high while any participating row i (i ≥ 1) has a limit below the limit of row i-1. It follows register contents and `dual_chan` with no added delay. A lookup issued while `cfg_err` is high returns `res_hit` = 0, `res_oor` = 0 and `res_row` = 0.
- R8: Reset clears all limits and all outputs. After reset, every lookup is out of range until limits are written.
- R9: `res_hit` and `res_oor` are never high together, and `res_row` is 0 whenever `res_hit` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Boundary register write strobe |
| wr_idx | input | 3 | Row whose boundary is written |
| wr_data | input | 8 | Boundary value; bits 6:0 used, bit 7 reserved |
| dual_chan | input | 1 | 1 = four participating rows, 0 = eight |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 33 | Physical byte address to decode |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Address falls inside a populated row |
| res_oor | output | 1 | Address lies beyond installed memory |
| res_row | output | 3 | Selected row index (0 when no hit) |
| cfg_err | output | 1 | Participating limits are not non-decreasing |

## Verification
The assertions assume the block is held in reset for at least one clock edge before any lookup, and that every input carries a known value at each edge. The dual-channel check samples `dual_chan` in the lookup cycle itself, so the mode may change between lookups without breaking any property. The stimulus meets these conditions: it holds reset for several cycles, drives every input from time zero, and changes inputs only on the falling edge. It also keeps `wr_idx` inside the eight-row range and limits lookup granules to values a 7-bit limit can reach or just exceed.

// File: rtl/rowbnd_pkg.sv
package rowbnd_pkg;

    // Outcome of one lookup, carried through the result register.
    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_HIT    = 2'd1,
        LK_OOR    = 2'd2,
        LK_BADCFG = 2'd3
    } lk_status_e;

    // Number of rows taking part in decoding for the selected channel mode.
    function automatic int unsigned live_rows(input logic dual, input int unsigned nrows);
        return dual ? (nrows / 2) : nrows;
    endfunction

    // True when row idx takes part in decoding.
    function automatic logic row_live(input int unsigned idx, input logic dual,
                                      input int unsigned nrows);
        return idx < live_rows(dual, nrows);
    endfunction

    // Fold request, configuration health and search outcome into one status.
    function automatic lk_status_e classify(input logic valid, input logic bad,
                                            input logic found);
        if (!valid)      return LK_IDLE;
        else if (bad)    return LK_BADCFG;
        else if (found)  return LK_HIT;
        else             return LK_OOR;
    endfunction

endpackage

// File: rtl/rowbnd_regs.sv
module rowbnd_regs
    import rowbnd_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 8,
    parameter int BND_USED = 7,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [ROW_W-1:0]                   wr_idx,
    input  logic [BND_W-1:0]                   wr_data,
    output logic [NUM_ROWS-1:0][BND_USED-1:0]  bnd_q
);

    // Reserved upper bits of the write data are dropped on purpose.
    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[BND_W-1:BND_USED];

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                bnd_q[g] <= '0;
            end else if (wr_en && (wr_idx == ROW_W'(g))) begin
                bnd_q[g] <= wr_data[BND_USED-1:0];
            end
        end
    end

endmodule

// File: rtl/rowbnd_order_chk.sv
module rowbnd_order_chk
    import rowbnd_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_USED = 7
) (
    input  logic [NUM_ROWS-1:0][BND_USED-1:0] bnd,
    input  logic                              dual,
    output logic                              cfg_err
);

    logic [NUM_ROWS-1:0] drop;

    assign drop[0] = 1'b0;
    for (genvar g = 1; g < NUM_ROWS; g++) begin : g_pair
        assign drop[g] = row_live(g, dual, NUM_ROWS) && (bnd[g] < bnd[g-1]);
    end

    assign cfg_err = |drop;

endmodule

// File: rtl/rowbnd_search.sv
module rowbnd_search
    import rowbnd_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_USED = 7,
    localparam int ROW_W   = $clog2(NUM_ROWS)
) (
    input  logic [NUM_ROWS-1:0][BND_USED-1:0] bnd,
    input  logic                              dual,
    input  logic [BND_USED-1:0]               granule,
    output logic                              found,
    output logic [ROW_W-1:0]                  row
);

    // One comparator per row: limit lies strictly above the granule.
    logic [NUM_ROWS-1:0] above;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
        assign above[g] = row_live(g, dual, NUM_ROWS) && (bnd[g] > granule);
    end

    // Lowest set bit wins; an empty row can never be the lowest one above.
    always_comb begin
        row = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (above[i]) begin
                row = ROW_W'(i);
            end
        end
    end

    assign found = |above;

endmodule

// File: rtl/rowbnd_decoder.sv
module rowbnd_decoder
    import rowbnd_pkg::*;
#(
    parameter int NUM_ROWS   = 8,
    parameter int BND_W      = 8,
    parameter int BND_USED   = 7,
    parameter int GRAN_SHIFT = 26,
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int ADDR_W    = GRAN_SHIFT + BND_USED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_idx,
    input  logic [BND_W-1:0]  wr_data,
    input  logic              dual_chan,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_oor,
    output logic [ROW_W-1:0]  res_row,
    output logic              cfg_err
);

    typedef struct packed {
        logic             valid;
        lk_status_e       status;
        logic [ROW_W-1:0] row;
    } result_t;

    logic [NUM_ROWS-1:0][BND_USED-1:0] bnd;
    logic [BND_USED-1:0]               granule;
    logic                              found;
    logic [ROW_W-1:0]                  found_row;
    result_t                           res_d, res_q;

    // Offset inside a granule does not affect row selection.
    logic unused_offset;
    assign unused_offset = ^lk_addr[GRAN_SHIFT-1:0];
    assign granule       = lk_addr[ADDR_W-1:GRAN_SHIFT];

    rowbnd_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BND_W    (BND_W),
        .BND_USED (BND_USED)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bnd_q   (bnd)
    );

    rowbnd_order_chk #(
        .NUM_ROWS (NUM_ROWS),
        .BND_USED (BND_USED)
    ) u_order (
        .bnd     (bnd),
        .dual    (dual_chan),
        .cfg_err (cfg_err)
    );

    rowbnd_search #(
        .NUM_ROWS (NUM_ROWS),
        .BND_USED (BND_USED)
    ) u_search (
        .bnd     (bnd),
        .dual    (dual_chan),
        .granule (granule),
        .found   (found),
        .row     (found_row)
    );

    always_comb begin
        res_d.valid  = lk_valid;
        res_d.status = classify(lk_valid, cfg_err, found);
        res_d.row    = (res_d.status == LK_HIT) ? found_row : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = (res_q.status == LK_HIT);
    assign res_oor   = (res_q.status == LK_OOR);
    assign res_row   = res_q.row;

endmodule

// File: rtl/rowbnd_decoder_sva.sv
module rowbnd_decoder_sva #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             dual_chan,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_oor,
    input logic [ROW_W-1:0] res_row,
    input logic             cfg_err
);

    // R6: a request yields a result on the next edge
    assert_result_follows_R6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R6: no request, no result
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R6: flags stay low without a result
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && !res_oor));

    // R9: hit and out-of-range exclusive
    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(res_hit && res_oor));

    // R9: row reads zero on a miss
    assert_row_zero_miss_R9: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_row == '0));

    // R4: in dual-channel mode a hit stays within the lower half
    assert_dual_half_R4: assert property (@(posedge clk) disable iff (rst)
        (res_hit && $past(dual_chan)) |-> (int'(res_row) < NUM_ROWS / 2));

    // R7: a bad configuration blocks both flags
    assert_badcfg_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(cfg_err)) |-> (!res_hit && !res_oor));

    // R8: reset clears results and limits
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit && !res_oor && !cfg_err));

endmodule

bind rowbnd_decoder rowbnd_decoder_sva #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W)
) i_sva (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .dual_chan (dual_chan),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_oor   (res_oor),
    .res_row   (res_row),
    .cfg_err   (cfg_err)
);

// File: tb/test_rowbnd_decoder.sv
module test_rowbnd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        dual_chan = 1'b0;
    logic        lk_valid = 1'b0;
    logic [32:0] lk_addr = '0;
    logic        res_valid, res_hit, res_oor, cfg_err;
    logic [2:0]  res_row;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string phase = "R8 reset";

    // reference state
    int mb[8];
    int e_valid = 0, e_hit = 0, e_oor = 0, e_row = 0;

    always #10 clk = ~clk;   // 50 MHz

    rowbnd_decoder i_rowbnd_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .dual_chan(dual_chan), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_oor(res_oor),
        .res_row(res_row), .cfg_err(cfg_err)
    );

    function automatic int n_live(input logic d);
        return d ? 4 : 8;
    endfunction

    function automatic bit model_bad(input logic d);
        bit b = 0;
        for (int i = 1; i < n_live(d); i++)
            if (mb[i] < mb[i-1]) b = 1;
        return b;
    endfunction

    // Reference behaviour, evaluated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            foreach (mb[i]) mb[i] = 0;
            e_valid = 0; e_hit = 0; e_oor = 0; e_row = 0;
        end else begin
            int gran;
            int pick;
            gran = int'(lk_addr[32:26]);
            pick = -1;
            for (int i = 0; i < n_live(dual_chan); i++)
                if (pick < 0 && mb[i] > gran) pick = i;
            e_valid = lk_valid;
            e_hit = 0; e_oor = 0; e_row = 0;
            if (lk_valid && !model_bad(dual_chan)) begin
                if (pick >= 0) begin e_hit = 1; e_row = pick; end
                else e_oor = 1;
            end
            if (wr_en) mb[wr_idx] = int'(wr_data[6:0]);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // Advance one cycle and compare every output against the reference
    task automatic cyc();
        @(negedge clk);
        chk("res_valid R6", int'(res_valid), e_valid);
        chk("res_hit R3",   int'(res_hit),   e_hit);
        chk("res_oor R5",   int'(res_oor),   e_oor);
        chk("res_row R3",   int'(res_row),   e_row);
        chk("cfg_err R7",   int'(cfg_err),   int'(model_bad(dual_chan)));
    endtask

    task automatic wr(input int idx, input int val);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(val);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic look(input int gran);
        lk_valid = 1'b1;
        lk_addr = {7'(gran), 26'($urandom)};
        cyc();
        lk_valid = 1'b0;
    endtask

    initial begin
        // R8: reset, including a lookup during reset
        lk_valid = 1'b1;
        repeat (3) cyc();
        lk_valid = 1'b0;
        rst = 1'b0;
        cyc();
        look(0);
        look(5);
        cyc();

        // R2 / R3: cumulative limits with empty rows 2 and 5
        phase = "R2/R3 decode";
        wr(0, 2); wr(1, 4); wr(2, 4); wr(3, 7);
        wr(4, 10); wr(5, 10); wr(6, 20); wr(7, 30);
        foreach (mb[i]) begin end
        for (int g = 0; g < 32; g++) look(g);
        look(127);
        cyc();

        // R1: reserved bit dropped; same-cycle lookup sees old value
        phase = "R1 write";
        wr_en = 1'b1; wr_idx = 3'd7; wr_data = 8'hA8;
        lk_valid = 1'b1; lk_addr = {7'd35, 26'd0};
        cyc();
        wr_en = 1'b0; lk_valid = 1'b0;
        look(35);
        look(40);
        wr(6, 8'h94);
        look(19);
        look(20);
        cyc();

        // R4: dual-channel uses only rows 0..3
        phase = "R4 dual";
        dual_chan = 1'b1;
        look(5); look(6); look(7); look(8); look(30);
        dual_chan = 1'b0;
        look(8);
        wr(5, 1);   // drop in upper half only
        cyc();
        dual_chan = 1'b1;
        cyc();
        look(1);
        look(9);

        // R7: decreasing pair blocks lookups
        phase = "R7 order";
        dual_chan = 1'b0;
        cyc();
        look(1);
        look(100);
        wr(5, 10);
        look(9);
        wr(2, 1);
        dual_chan = 1'b1;
        cyc();
        look(0);
        wr(2, 4);
        look(3);
        dual_chan = 1'b0;
        cyc();

        // R9: random mix of writes, lookups and mode changes
        phase = "R9 random";
        for (int n = 0; n < 3000; n++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            wr_idx = 3'($urandom_range(0, 7));
            wr_data = 8'(($urandom_range(0, 1) << 7) | (wr_idx * 9 + $urandom_range(0, 12)));
            lk_valid = ($urandom_range(0, 2) != 0);
            lk_addr = {7'($urandom_range(0, 90)), 26'($urandom)};
            if ($urandom_range(0, 31) == 0) dual_chan = ~dual_chan;
            cyc();
        end
        wr_en = 1'b0; lk_valid = 1'b0;
        cyc();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL [%s] watchdog: actual hung expected finished", phase);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule